// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block is a single-channel SPI master. A host writes a character into a one-deep transmit holding register. The controller moves that character into a shift register and produces a serial clock derived from the system clock. It shifts the character out on `mosi` while it collects a character from `miso`. When the last clock edge has passed, the collected character goes to the receive holding register and the receive flag is raised.

Static control inputs select the following at run time:

- the serial clock idle level and the clock phase;
- most-significant-bit-first or least-significant-bit-first order;
- a full-width character or one bit shorter;
- a loopback mode in which the receiver listens to the block's own transmit line;
- the behaviour of a slave-enable output, which can be unused, active high or active low.

A software-reset input holds all transfer logic idle. The control inputs are expected to stay stable while a transfer runs.

Top module: `spi_master_core`

## Requirements
- R1: While `rst_n` is low or `swReset` is 1, the block holds these values: `txEmpty`=1, `rxFull`=0, `busy`=0, `overrun`=0, `mosi`=0 and `sclk`=`clkPol`. A `txWrite` given while `swReset` is 1 is discarded, and no transfer follows once `swReset` returns to 0. Raising `swReset` during a transfer aborts it at the next clock edge.
- R2: A `txWrite` sampled at clock edge P0 into an idle block drops `txEmpty` after P0. At P1 the transfer starts: `busy` becomes 1 and `txEmpty` returns to 1.
- R3: Whenever no transfer runs, `sclk` equals `clkPol`: low for 0 and high for 1.
- R4: Data is captured and changed on these edges:
  - `clkPol`=0, `clkPha`=0: captured on falling edges, changed on rising edges.
  - `clkPol`=0, `clkPha`=1: captured on rising edges, changed on falling edges.
  - `clkPol`=1, `clkPha`=0: captured on rising edges, changed on falling edges.
  - `clkPol`=1, `clkPha`=1: captured on falling edges, changed on rising edges.
  
  With `clkPha`=1 the first edge is a capture edge. With `clkPha`=0 the first edge is a change edge. The received character appears on `rxData` together with `rxFull`.
- R5: `msbFirst`=1 sends and receives the highest character bit first. `msbFirst`=0 sends and receives bit 0 first.
- R6: `shortChar`=0 transfers 8 bits using 16 `sclk` edges. `shortChar`=1 transfers 7 bits (bits 6..0) using 14 edges. In the 7-bit case `txData` bit 7 is never sent and `rxData` bit 7 reads 0.
- R7: Each `sclk` half-period lasts N system clocks, where N is `divider` and a value of 0 counts as 1. A transfer of L bits keeps `busy` high for exactly 2·L·N cycles.
- R8: With `listenEn`=1 the receiver takes its bits from the block's own `mosi` and ignores `miso`, so `rxData` equals the transmitted character.
- R9: `overrun` is set when a transfer completes while `rxFull` is still 1 and no read occurs in that cycle. `rxData` then holds the newest character. An `rxRead` clears `overrun`.
- R10: A `txWrite` during a transfer holds the character (`txEmpty`=0). That character starts one cycle after the current transfer completes, so `busy` is low for exactly one cycle between the two transfers.
- R11: `slaveEn` depends on `pinMode`:
  - `pinMode`=01: `slaveEn` equals `busy`.
  - `pinMode`=10: `slaveEn` equals the inverse of `busy`.
  - `pinMode`=00 or 11: `slaveEn` is 0.
- R12: An `rxRead` sampled while no transfer completes clears `rxFull` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| swReset | input | 1 | Holds transfer logic idle while 1 |
| clkPol | input | 1 | Serial clock idle level |
| clkPha | input | 1 | 1 = capture on first edge, 0 = change on first edge |
| msbFirst | input | 1 | Bit order select |
| shortChar | input | 1 | 1 = 7-bit characters |
| listenEn | input | 1 | Internal loopback of mosi into the receiver |
| pinMode | input | 2 | Slave-enable behaviour (see R11) |
| divider | input | 16 | Half-period length in system clocks |
| txWrite | input | 1 | Write strobe for the transmit holding register |
| txData | input | 8 | Character to send |
| rxRead | input | 1 | Read strobe that acknowledges rxData |
| miso | input | 1 | Serial data from the slave |
| rxData | output | 8 | Last received character |
| txEmpty | output | 1 | Transmit holding register can accept a character |
| rxFull | output | 1 | Unread character present in rxData |
| busy | output | 1 | A character is being shifted |
| overrun | output | 1 | A received character was overwritten unread |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| slaveEn | output | 1 | Slave-enable output |

## Verification
Take a write sampled at edge P0. `txEmpty` falls after P0, and `busy` and the start of shifting follow after P1. Completion comes after edge P(1+2·L·N): `busy` falls there, and `rxFull`, `rxData` and `overrun` update together at that edge. The bench counts exactly those rising edges and samples every output on the falling edge that follows. It checks `busy` both one cycle before and at the completion edge, so any error in the divider or the edge count is caught. For queued characters it checks the single idle cycle between transfers. A bench-side slave shifts and records bits on edges chosen only from the polarity and phase rules, so bit order, length and edge selection are judged independently of the design.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

  // One-cycle strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;       // move holding register into the shift register
    logic shiftTx;    // present the next transmit bit
    logic captureRx;  // sample the receive input
    logic finish;     // last serial clock edge of the character
  } spiStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrlState_t;

  typedef enum logic [1:0] {
    PIN_THREE   = 2'b00,
    PIN_FOUR_HI = 2'b01,
    PIN_FOUR_LO = 2'b10,
    PIN_RSVD    = 2'b11
  } pinMode_t;

endpackage

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swReset,
  input  logic              clkPha,
  input  logic              shortChar,
  input  logic [DIV_W-1:0]  divider,
  input  logic              txPending,
  output spiStrobes_t       strobes,
  output logic              busy,
  output logic              sclkPhase
);

  localparam int EDGE_W = $clog2(2 * DATA_W + 1);
  localparam logic [EDGE_W-1:0] EDGES_LONG  = EDGE_W'(2 * DATA_W);
  localparam logic [EDGE_W-1:0] EDGES_SHORT = EDGE_W'(2 * (DATA_W - 1));

  ctrlState_t        state;
  logic [DIV_W-1:0]  halfCnt;
  logic [DIV_W-1:0]  halfLast;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] edgeLast;
  logic              edgeEv;
  logic              captureSel;

  always_comb begin
    // a divider of zero behaves like one
    halfLast   = (divider == '0) ? '0 : divider - 1'b1;
    edgeLast   = (shortChar ? EDGES_SHORT : EDGES_LONG) - 1'b1;
    edgeEv     = (state == ST_RUN) && (halfCnt == halfLast);
    // edgeCnt holds edges already done; the coming edge is edgeCnt+1
    captureSel = clkPha ? ~edgeCnt[0] : edgeCnt[0];

    strobes.load      = (state == ST_IDLE) && txPending && !swReset;
    strobes.captureRx = edgeEv && captureSel;
    // first bit is presented at load, so the very first edge never shifts
    strobes.shiftTx   = edgeEv && !captureSel && (edgeCnt != '0);
    strobes.finish    = edgeEv && (edgeCnt == edgeLast);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      halfCnt   <= '0;
      edgeCnt   <= '0;
      sclkPhase <= 1'b0;
    end else if (swReset) begin
      state     <= ST_IDLE;
      halfCnt   <= '0;
      edgeCnt   <= '0;
      sclkPhase <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strobes.load) begin
            state     <= ST_RUN;
            halfCnt   <= '0;
            edgeCnt   <= '0;
            sclkPhase <= 1'b0;
          end
        end
        ST_RUN: begin
          if (edgeEv) begin
            halfCnt   <= '0;
            sclkPhase <= ~sclkPhase;
            edgeCnt   <= edgeCnt + 1'b1;
            if (strobes.finish) state <= ST_IDLE;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_RUN);

endmodule

// File: rtl/spi_master_datapath.sv
module spi_master_datapath
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swReset,
  input  spiStrobes_t       strobes,
  input  logic              msbFirst,
  input  logic              shortChar,
  input  logic              listenEn,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  input  logic              miso,
  output logic              mosi,
  output logic              txEmpty,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              overrun
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] txBuf;
  logic [DATA_W-1:0] sendVec;    // bit 0 is always the bit on the wire
  logic [DATA_W-1:0] sendOrder;
  logic [DATA_W-1:0] rxAcc;      // bit i is the i-th bit received
  logic [DATA_W-1:0] rxMerged;
  logic [DATA_W-1:0] rxWord;
  logic [IDX_W-1:0]  rxIdx;
  logic              inBit;

  assign mosi  = sendVec[0];
  assign inBit = listenEn ? sendVec[0] : miso;

  // Put the holding register into wire order once, at load time
  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      sendOrder[i] = msbFirst ? txBuf[DATA_W-1-i] : txBuf[i];
    if (shortChar && msbFirst) begin
      for (int i = 0; i < DATA_W - 1; i++)
        sendOrder[i] = txBuf[DATA_W-2-i];
      sendOrder[DATA_W-1] = 1'b0;
    end
  end

  // Include a capture that coincides with the final edge
  always_comb begin
    rxMerged = rxAcc;
    if (strobes.captureRx) rxMerged[rxIdx] = inBit;
  end

  // Wire order back to character order
  always_comb begin
    for (int j = 0; j < DATA_W; j++)
      rxWord[j] = msbFirst ? rxMerged[DATA_W-1-j] : rxMerged[j];
    if (shortChar) begin
      if (msbFirst) begin
        for (int j = 0; j < DATA_W - 1; j++)
          rxWord[j] = rxMerged[DATA_W-2-j];
      end
      rxWord[DATA_W-1] = 1'b0;
    end
  end

  // Transmit side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txBuf   <= '0;
      txEmpty <= 1'b1;
      sendVec <= '0;
    end else if (swReset) begin
      txBuf   <= '0;
      txEmpty <= 1'b1;
      sendVec <= '0;
    end else begin
      if (txWrite) begin
        txBuf   <= txData;
        txEmpty <= 1'b0;
      end else if (strobes.load) begin
        txEmpty <= 1'b1;
      end
      if (strobes.load)         sendVec <= sendOrder;
      else if (strobes.shiftTx) sendVec <= sendVec >> 1;
    end
  end

  // Receive side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxAcc   <= '0;
      rxIdx   <= '0;
      rxData  <= '0;
      rxFull  <= 1'b0;
      overrun <= 1'b0;
    end else if (swReset) begin
      rxAcc   <= '0;
      rxIdx   <= '0;
      rxData  <= '0;
      rxFull  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (strobes.load) begin
        rxAcc <= '0;
        rxIdx <= '0;
      end else if (strobes.captureRx) begin
        rxAcc <= rxMerged;
        rxIdx <= rxIdx + 1'b1;
      end

      if (strobes.finish) begin
        rxData <= rxWord;
        rxFull <= 1'b1;
      end else if (rxRead) begin
        rxFull <= 1'b0;
      end

      if (strobes.finish && rxFull && !rxRead) overrun <= 1'b1;
      else if (rxRead)                         overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swReset,
  input  logic              clkPol,
  input  logic              clkPha,
  input  logic              msbFirst,
  input  logic              shortChar,
  input  logic              listenEn,
  input  logic [1:0]        pinMode,
  input  logic [DIV_W-1:0]  divider,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  input  logic              miso,
  output logic [DATA_W-1:0] rxData,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              busy,
  output logic              overrun,
  output logic              sclk,
  output logic              mosi,
  output logic              slaveEn
);

  spiStrobes_t strobes;
  logic        sclkPhase;

  spi_master_ctrl #(
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .swReset   (swReset),
    .clkPha    (clkPha),
    .shortChar (shortChar),
    .divider   (divider),
    .txPending (~txEmpty),
    .strobes   (strobes),
    .busy      (busy),
    .sclkPhase (sclkPhase)
  );

  spi_master_datapath #(
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .swReset   (swReset),
    .strobes   (strobes),
    .msbFirst  (msbFirst),
    .shortChar (shortChar),
    .listenEn  (listenEn),
    .txWrite   (txWrite),
    .txData    (txData),
    .rxRead    (rxRead),
    .miso      (miso),
    .mosi      (mosi),
    .txEmpty   (txEmpty),
    .rxData    (rxData),
    .rxFull    (rxFull),
    .overrun   (overrun)
  );

  // Idle level comes from the polarity; the phase register toggles per edge
  assign sclk = clkPol ^ sclkPhase;

  always_comb begin
    case (pinMode_t'(pinMode))
      PIN_FOUR_HI: slaveEn = busy;
      PIN_FOUR_LO: slaveEn = ~busy;
      default:     slaveEn = 1'b0;
    endcase
  end

endmodule

// File: rtl/spi_master_core_chk.sv
module spi_master_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       swReset,
  input logic       clkPol,
  input logic [1:0] pinMode,
  input logic       txWrite,
  input logic       rxRead,
  input logic       txEmpty,
  input logic       rxFull,
  input logic       busy,
  input logic       overrun,
  input logic       sclk,
  input logic       slaveEn
);

  // R1
  sw_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swReset |=> (txEmpty && !busy && !rxFull && !overrun));

  // R2
  start_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!txEmpty));

  // R2
  write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txEmpty) |-> $past(txWrite));

  // R3
  sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sclk) && $stable(clkPol)) |-> $past(busy));

  // R9
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rxFull));

  // R11
  enable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pinMode == 2'b01) |-> slaveEn);

  // R12
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxRead && !busy) |=> !rxFull);

endmodule

bind spi_master_core spi_master_core_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .swReset (swReset),
  .clkPol  (clkPol),
  .pinMode (pinMode),
  .txWrite (txWrite),
  .rxRead  (rxRead),
  .txEmpty (txEmpty),
  .rxFull  (rxFull),
  .busy    (busy),
  .overrun (overrun),
  .sclk    (sclk),
  .slaveEn (slaveEn)
);

// File: tb/spi_master_core_tb.sv
`timescale 1ns/1ps
module spi_master_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        swReset = 1'b0;
  logic        clkPol = 1'b0;
  logic        clkPha = 1'b0;
  logic        msbFirst = 1'b1;
  logic        shortChar = 1'b0;
  logic        listenEn = 1'b0;
  logic [1:0]  pinMode = 2'b00;
  logic [15:0] divider = 16'd1;
  logic        txWrite = 1'b0;
  logic [7:0]  txData = 8'h00;
  logic        rxRead = 1'b0;
  logic        miso = 1'b0;
  logic [7:0]  rxData;
  logic        txEmpty, rxFull, busy, overrun, sclk, mosi, slaveEn;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spi_master_core u_dut (
    .clk(clk), .rst_n(rst_n), .swReset(swReset), .clkPol(clkPol), .clkPha(clkPha),
    .msbFirst(msbFirst), .shortChar(shortChar), .listenEn(listenEn), .pinMode(pinMode),
    .divider(divider), .txWrite(txWrite), .txData(txData), .rxRead(rxRead), .miso(miso),
    .rxData(rxData), .txEmpty(txEmpty), .rxFull(rxFull), .busy(busy), .overrun(overrun),
    .sclk(sclk), .mosi(mosi), .slaveEn(slaveEn)
  );

  // Bench-side slave: edge roles come only from the polarity/phase rules (R4)
  logic slvActive = 1'b0;
  logic slvBits  [8];
  logic mosiBits [8];
  int   capIdx = 0;
  int   edgeSeen = 0;

  always @(sclk) begin
    if (slvActive) begin
      edgeSeen = edgeSeen + 1;
      if (sclk == (clkPol ^ clkPha)) begin
        if (capIdx < 8) mosiBits[capIdx] = mosi;
        capIdx = capIdx + 1;
      end else begin
        if (capIdx < 8) miso = slvBits[capIdx];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doXfer(input logic [15:0] div, input logic [7:0] tx,
                        input logic [7:0] slv, input logic doRead);
    int L = shortChar ? 7 : 8;
    int N = (div == 16'd0) ? 1 : int'(div);
    logic [7:0] mask = shortChar ? 8'h7F : 8'hFF;
    logic [7:0] word = 8'h00;
    logic [7:0] expRx;
    divider = div;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      slvBits[i]  = (i < L) ? (msbFirst ? slv[L-1-i] : slv[i]) : 1'b0;
      mosiBits[i] = 1'b0;
    end
    capIdx = 0;
    edgeSeen = 0;
    miso = slvBits[0];
    slvActive = 1'b1;
    txWrite = 1'b1;
    txData = tx;
    @(posedge clk);                     // P0
    @(negedge clk);
    txWrite = 1'b0;
    chk("R2 txEmpty after write", txEmpty, 1'b0);
    chk("R2 busy before start", busy, 1'b0);
    @(posedge clk);                     // P1
    @(negedge clk);
    chk("R2 busy at start", busy, 1'b1);
    chk("R2 txEmpty at start", txEmpty, 1'b1);
    chk("R11 slaveEn busy", slaveEn, pinMode == 2'b01);
    repeat (2 * L * N - 1) @(posedge clk);
    @(negedge clk);
    chk("R7 busy before last edge", busy, 1'b1);
    @(posedge clk);
    @(negedge clk);
    slvActive = 1'b0;
    chk("R7 busy after last edge", busy, 1'b0);
    chk("R2 rxFull at end", rxFull, 1'b1);
    chk("R3 sclk idle level", sclk, clkPol);
    chk("R6 edge count", edgeSeen, 2 * L);
    chk("R11 slaveEn idle", slaveEn, pinMode == 2'b10);
    expRx = listenEn ? (tx & mask) : (slv & mask);
    chk(listenEn ? "R8 loopback rxData" : "R4 R5 rxData", rxData, expRx);
    for (int j = 0; j < L; j++)
      word[j] = msbFirst ? mosiBits[L-1-j] : mosiBits[j];
    chk("R5 R6 mosi character", word, tx & mask);
    if (doRead) begin
      rxRead = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rxRead = 1'b0;
      chk("R12 rxFull cleared", rxFull, 1'b0);
    end
  endtask

  // {pol, pha, msb, short, listen, div[15:0], tx[7:0], slave[7:0]}
  localparam logic [36:0] VECS [8] = '{
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'd2, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd1, 8'h96, 8'hC3},
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd3, 8'h1E, 8'h81},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0, 8'h7B, 8'h5A},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'd2, 8'hFF, 8'h6D},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'd1, 8'h55, 8'h92},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd1, 8'hC6, 8'h00},
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'd4, 8'h3B, 8'hFF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 reset txEmpty", txEmpty, 1'b1);
    chk("R1 reset rxFull", rxFull, 1'b0);
    chk("R1 reset busy", busy, 1'b0);
    chk("R1 reset overrun", overrun, 1'b0);
    chk("R1 reset mosi", mosi, 1'b0);
    chk("R3 idle low", sclk, 1'b0);
    clkPol = 1'b1;
    #1;
    chk("R3 idle high", sclk, 1'b1);
    rst_n = 1'b1;

    // Table walk
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      {clkPol, clkPha, msbFirst, shortChar, listenEn} = VECS[v][36:32];
      pinMode = 2'(v % 4);
      doXfer(VECS[v][31:16], VECS[v][15:8], VECS[v][7:0], 1'b1);
    end

    // R1 writes ignored while held in software reset
    @(negedge clk);
    clkPol = 1'b0; clkPha = 1'b1; msbFirst = 1'b1; shortChar = 1'b0; listenEn = 1'b0;
    pinMode = 2'b01; divider = 16'd1;
    swReset = 1'b1;
    txWrite = 1'b1; txData = 8'hE7;
    @(negedge clk);
    txWrite = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 write ignored txEmpty", txEmpty, 1'b1);
    chk("R1 held busy", busy, 1'b0);
    swReset = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 no transfer after release", busy, 1'b0);
    chk("R1 still empty after release", txEmpty, 1'b1);

    // R1 abort mid transfer
    txWrite = 1'b1; txData = 8'h81;
    @(negedge clk);
    txWrite = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 running before abort", busy, 1'b1);
    swReset = 1'b1;
    @(negedge clk);
    chk("R1 abort busy", busy, 1'b0);
    chk("R1 abort sclk", sclk, clkPol);
    chk("R11 abort slaveEn", slaveEn, 1'b0);
    swReset = 1'b0;

    // R9 overrun on two unread characters
    @(negedge clk);
    pinMode = 2'b00;
    doXfer(16'd1, 8'h12, 8'hA1, 1'b0);
    chk("R9 no overrun after first", overrun, 1'b0);
    doXfer(16'd1, 8'h34, 8'h5E, 1'b0);
    chk("R9 overrun set", overrun, 1'b1);
    chk("R9 newest data kept", rxData, 8'h5E);
    rxRead = 1'b1;
    @(negedge clk);
    rxRead = 1'b0;
    chk("R9 overrun cleared by read", overrun, 1'b0);
    chk("R12 rxFull cleared", rxFull, 1'b0);

    // R10 write held during a transfer, started right after
    listenEn = 1'b1; divider = 16'd1; shortChar = 1'b0;
    @(negedge clk);
    txWrite = 1'b1; txData = 8'hC9;
    @(posedge clk);                     // P0
    @(posedge clk);                     // P1
    @(negedge clk);
    txData = 8'h4D;
    @(posedge clk);                     // P2
    @(negedge clk);
    txWrite = 1'b0;
    chk("R10 held while busy", txEmpty, 1'b0);
    chk("R10 first running", busy, 1'b1);
    repeat (14) @(posedge clk);         // P16
    @(negedge clk);
    chk("R10 busy before first end", busy, 1'b1);
    @(posedge clk);                     // P17
    @(negedge clk);
    chk("R10 gap cycle", busy, 1'b0);
    chk("R10 still pending", txEmpty, 1'b0);
    chk("R10 first data", rxData, 8'hC9);
    rxRead = 1'b1;
    @(posedge clk);                     // P18
    @(negedge clk);
    rxRead = 1'b0;
    chk("R10 second started", busy, 1'b1);
    chk("R10 buffer drained", txEmpty, 1'b1);
    chk("R12 read during start", rxFull, 1'b0);
    repeat (15) @(posedge clk);         // P33
    @(negedge clk);
    chk("R10 second still busy", busy, 1'b1);
    @(posedge clk);                     // P34
    @(negedge clk);
    chk("R10 second done", busy, 1'b0);
    chk("R10 second data", rxData, 8'h4D);
    chk("R9 no overrun after read", overrun, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule